// File: doc/BRIEF.md
# Dual-Issue Dispatch with Renaming

This block sits between the head of an instruction queue and a pool of reservation stations. In every cycle it looks at the two oldest decoded instructions, called slot 0 and slot 1. For each one it picks a free station of the class the opcode needs: adder, multiplier, load or store. It rewrites each source register into the tag of the station that will produce its value, and puts the result on one of two outgoing instruction buses. A two-bit take signal tells the queue which of the two slots were consumed.

Station occupancy comes in as a busy map and register ownership comes in as a rename table, so the block keeps no copy of either. A tag-return bus reports stations that finish in the current cycle. The block uses it in two ways. A station being returned counts as free. A register whose owner is being returned reads as the register itself. Renaming also works inside the issue pair. Slot 1 may overtake a stalled slot 0 only when the two are independent. A raised exception stops all issue until reset.

Top module: `dual_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, both bus words and `take_o` are zero.
- R2: Stations are chosen by opcode class: opcodes 2–3 use tags 8–9, 4–5 use 10–11, 6 uses 12–13 and 7 uses 14–15. Slot 0 gets the lowest free tag of its class. Slot 1 gets the lowest free tag left over. The two tags are never equal.
- R3: A station is free when its bit in `busy_i` is clear (bit j stands for tag 8+j), or when its tag appears on any channel of `ret_i` in the same cycle.
- R4: When no station of its class is free, a slot drives an all-zero word and its `take_o` bit stays clear.
- R5: A source register tag 4+i is replaced by entry i of `rmap_i` (bits 4i+3:4i) when that entry is non-zero and is not on `ret_i`. Otherwise the register tag passes through unchanged.
- R6: When slot 1 reads the register that slot 0 writes, that source becomes slot 0's station tag. This overrides the rename table.
- R7: When slot 0 is valid but gets no station, slot 1 stalls if it depends on slot 0 and issues alone (take 2'b10) if it does not. Dependence means any of the following: slot 1 reads slot 0's destination; both write the same register; slot 1 writes a register that slot 0 reads; both are memory operations.
- R8: The bus word is {op[50:48], station[47:44], dest[43:40], srcA[39:36], srcB[35:32], addr[31:0]}. Arithmetic words carry a zero address. LOAD words carry zero sources. STOR words carry zero in dest and srcB.
- R9: Once `exc_i` is seen high, nothing more issues until reset, even after `exc_i` drops.
- R10: Bus words and `take_o` are registered and show the inputs from the previous rising edge. An opcode of 0 or 1 marks an empty slot, which produces a zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_i | input | 1 | Exception raised; stops issue permanently |
| op0_i | input | 3 | Slot 0 opcode |
| dst0_i | input | 4 | Slot 0 destination register tag |
| srca0_i | input | 4 | Slot 0 first source register tag |
| srcb0_i | input | 4 | Slot 0 second source register tag |
| addr0_i | input | ADDRW | Slot 0 memory address |
| op1_i | input | 3 | Slot 1 opcode |
| dst1_i | input | 4 | Slot 1 destination register tag |
| srca1_i | input | 4 | Slot 1 first source register tag |
| srcb1_i | input | 4 | Slot 1 second source register tag |
| addr1_i | input | ADDRW | Slot 1 memory address |
| busy_i | input | 8 | Station busy map, bit j = tag 8+j |
| rmap_i | input | NREG*4 | Rename table, one tag per register |
| ret_i | input | NRET*4 | Tags returned this cycle, one per channel |
| bus0_o | output | 3+16+ADDRW | Slot 0 instruction bus word |
| bus1_o | output | 3+16+ADDRW | Slot 1 instruction bus word |
| take_o | output | 2 | Bit k set when slot k was consumed |

## Verification
The case that is hardest to reach from the ports is slot 1 overtaking a stalled slot 0. To get there, the bench must fill every station of slot 0's class through the busy map while leaving slot 1's class open. It must then give the pair no dependence, or exactly one kind of dependence (read-after-write, or write-after-read), so that each dependence rule is checked on its own. A second difficult point is a station that is busy but is being returned in the same cycle. The bench covers it by raising a busy bit and placing the same tag on a non-zero return channel. The result is one grant to slot 0 while slot 1 of the same class still starves.

// File: rtl/dd_pkg.sv
package dd_pkg;

  localparam int OPW       = 3;
  localparam int TW        = 4;
  localparam int NCLASS    = 4;
  localparam int PER_CLASS = 2;
  localparam int NSTN      = NCLASS * PER_CLASS;
  localparam int STN_FIRST = 8;
  localparam int NTAGS     = 1 << TW;

  typedef logic [TW-1:0]  tag_t;
  typedef logic [OPW-1:0] op_t;

  localparam op_t OP_ADD = 3'd2;
  localparam op_t OP_SUB = 3'd3;
  localparam op_t OP_MUL = 3'd4;
  localparam op_t OP_DIV = 3'd5;
  localparam op_t OP_LD  = 3'd6;
  localparam op_t OP_ST  = 3'd7;

  localparam tag_t REG_FIRST = 4'd4;

  function automatic tag_t class_base(op_t op);
    case (op)
      OP_ADD, OP_SUB: class_base = 4'd8;
      OP_MUL, OP_DIV: class_base = 4'd10;
      OP_LD:          class_base = 4'd12;
      OP_ST:          class_base = 4'd14;
      default:        class_base = 4'd0;
    endcase
  endfunction

  function automatic logic has_dst(op_t op);
    has_dst = (op >= OP_ADD) && (op <= OP_LD);
  endfunction

  function automatic logic reads_a(op_t op);
    reads_a = ((op >= OP_ADD) && (op <= OP_DIV)) || (op == OP_ST);
  endfunction

  function automatic logic reads_b(op_t op);
    reads_b = (op >= OP_ADD) && (op <= OP_DIV);
  endfunction

  function automatic logic is_mem(op_t op);
    is_mem = (op == OP_LD) || (op == OP_ST);
  endfunction

endpackage

// File: rtl/dd_alloc.sv
module dd_alloc
  import dd_pkg::*;
#(
  parameter int PERC = PER_CLASS
) (
  input  op_t              op0_i,
  input  op_t              op1_i,
  input  logic [NTAGS-1:0] free_i,
  output tag_t             gnt0_o,
  output tag_t             gnt1_o
);

  tag_t             base0;
  tag_t             base1;
  logic [NTAGS-1:0] free_left;

  // slot 0: lowest free station of its class
  always_comb begin
    base0  = class_base(op0_i);
    gnt0_o = '0;
    if (base0 != '0) begin
      for (int s = PERC - 1; s >= 0; s--) begin
        if (free_i[base0 + tag_t'(s)]) gnt0_o = base0 + tag_t'(s);
      end
    end
  end

  // slot 1: lowest station still free after slot 0's pick
  always_comb begin
    free_left = free_i;
    if (gnt0_o != '0) free_left[gnt0_o] = 1'b0;
    base1  = class_base(op1_i);
    gnt1_o = '0;
    if (base1 != '0) begin
      for (int s = PERC - 1; s >= 0; s--) begin
        if (free_left[base1 + tag_t'(s)]) gnt1_o = base1 + tag_t'(s);
      end
    end
  end

endmodule

// File: rtl/dd_rename.sv
module dd_rename
  import dd_pkg::*;
#(
  parameter int NREG = 4,
  parameter int NRET = 4
) (
  input  tag_t               src_i,
  input  logic [NREG*TW-1:0] map_i,
  input  logic [NRET*TW-1:0] ret_i,
  input  logic               fwd_en_i,
  input  tag_t               fwd_reg_i,
  input  tag_t               fwd_tag_i,
  output tag_t               tag_o
);

  localparam tag_t REG_LAST = REG_FIRST + tag_t'(NREG - 1);

  tag_t owner;
  tag_t idx;
  logic owner_leaving;

  always_comb begin
    owner = '0;
    idx   = src_i - REG_FIRST;
    if ((src_i >= REG_FIRST) && (src_i <= REG_LAST)) owner = map_i[idx*TW +: TW];
    owner_leaving = 1'b0;
    for (int k = 0; k < NRET; k++) begin
      if (ret_i[k*TW +: TW] == owner) owner_leaving = 1'b1;
    end
    tag_o = src_i;
    if ((owner != '0) && !owner_leaving) tag_o = owner;
    // same-pair producer wins over the table
    if (fwd_en_i && (src_i != '0) && (src_i == fwd_reg_i)) tag_o = fwd_tag_i;
  end

endmodule

// File: rtl/dd_pack.sv
module dd_pack
  import dd_pkg::*;
#(
  parameter int ADDRW = 32
) (
  input  op_t                        op_i,
  input  tag_t                       stn_i,
  input  tag_t                       dst_i,
  input  tag_t                       sa_i,
  input  tag_t                       sb_i,
  input  logic [ADDRW-1:0]           addr_i,
  output logic [OPW+4*TW+ADDRW-1:0]  word_o
);

  localparam int SB_LSB  = ADDRW;
  localparam int SA_LSB  = SB_LSB + TW;
  localparam int DST_LSB = SA_LSB + TW;
  localparam int STN_LSB = DST_LSB + TW;
  localparam int OP_LSB  = STN_LSB + TW;

  always_comb begin
    word_o = '0;
    if (stn_i != '0) begin
      word_o[OP_LSB +: OPW] = op_i;
      word_o[STN_LSB +: TW] = stn_i;
      case (op_i)
        OP_LD: begin
          word_o[DST_LSB +: TW]  = dst_i;
          word_o[0 +: ADDRW]     = addr_i;
        end
        OP_ST: begin
          word_o[SA_LSB +: TW]   = sa_i;
          word_o[0 +: ADDRW]     = addr_i;
        end
        default: begin
          word_o[DST_LSB +: TW]  = dst_i;
          word_o[SA_LSB +: TW]   = sa_i;
          word_o[SB_LSB +: TW]   = sb_i;
        end
      endcase
    end
  end

endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch
  import dd_pkg::*;
#(
  parameter int ADDRW = 32,
  parameter int NREG  = 4,
  parameter int NRET  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         exc_i,
  input  logic [2:0]                   op0_i,
  input  logic [3:0]                   dst0_i,
  input  logic [3:0]                   srca0_i,
  input  logic [3:0]                   srcb0_i,
  input  logic [ADDRW-1:0]             addr0_i,
  input  logic [2:0]                   op1_i,
  input  logic [3:0]                   dst1_i,
  input  logic [3:0]                   srca1_i,
  input  logic [3:0]                   srcb1_i,
  input  logic [ADDRW-1:0]             addr1_i,
  input  logic [7:0]                   busy_i,
  input  logic [NREG*4-1:0]            rmap_i,
  input  logic [NRET*4-1:0]            ret_i,
  output logic [3+16+ADDRW-1:0]        bus0_o,
  output logic [3+16+ADDRW-1:0]        bus1_o,
  output logic [1:0]                   take_o
);

  localparam int WW      = OPW + 4 * TW + ADDRW;
  localparam int STN_LSB = ADDRW + 3 * TW;
  localparam int OP_LSB  = ADDRW + 4 * TW;
  localparam int NSRC    = 4;

  // ---------------- free map: idle or leaving this cycle
  logic [NTAGS-1:0] free_map;
  assign free_map[STN_FIRST-1:0] = '0;

  for (genvar j = 0; j < NSTN; j++) begin : g_free
    logic leaving;
    always_comb begin
      leaving = 1'b0;
      for (int k = 0; k < NRET; k++) begin
        if (ret_i[k*TW +: TW] == tag_t'(STN_FIRST + j)) leaving = 1'b1;
      end
    end
    assign free_map[STN_FIRST + j] = ~busy_i[j] | leaving;
  end

  // ---------------- station choice
  tag_t gnt0, gnt1;

  dd_alloc #(.PERC(PER_CLASS)) u_alloc (
    .op0_i  (op0_i),
    .op1_i  (op1_i),
    .free_i (free_map),
    .gnt0_o (gnt0),
    .gnt1_o (gnt1)
  );

  // ---------------- issue decision
  logic halted_q;
  logic issue_ok;
  logic slot0_live;
  logic dep;
  tag_t stn0, stn1;

  assign issue_ok   = ~exc_i & ~halted_q;
  assign slot0_live = class_base(op0_i) != '0;

  always_comb begin
    dep = 1'b0;
    if (has_dst(op0_i)) begin
      if (reads_a(op1_i) && (srca1_i == dst0_i)) dep = 1'b1;
      if (reads_b(op1_i) && (srcb1_i == dst0_i)) dep = 1'b1;
      if (has_dst(op1_i) && (dst1_i == dst0_i)) dep = 1'b1;
    end
    if (has_dst(op1_i)) begin
      if (reads_a(op0_i) && (srca0_i == dst1_i)) dep = 1'b1;
      if (reads_b(op0_i) && (srcb0_i == dst1_i)) dep = 1'b1;
    end
    if (is_mem(op0_i) && is_mem(op1_i)) dep = 1'b1;
  end

  always_comb begin
    stn0 = issue_ok ? gnt0 : '0;
    stn1 = '0;
    if (issue_ok && !(slot0_live && (stn0 == '0) && dep)) stn1 = gnt1;
  end

  // ---------------- source renaming, four lookups
  tag_t src_raw [NSRC];
  tag_t src_ren [NSRC];

  assign src_raw[0] = srca0_i;
  assign src_raw[1] = srcb0_i;
  assign src_raw[2] = srca1_i;
  assign src_raw[3] = srcb1_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_ren
    localparam bit SECOND = (g >= 2);
    dd_rename #(.NREG(NREG), .NRET(NRET)) u_ren (
      .src_i     (src_raw[g]),
      .map_i     (rmap_i),
      .ret_i     (ret_i),
      .fwd_en_i  (SECOND && has_dst(op0_i)),
      .fwd_reg_i (dst0_i),
      .fwd_tag_i (stn0),
      .tag_o     (src_ren[g])
    );
  end

  // ---------------- bus words
  logic [WW-1:0] word0_n, word1_n;

  dd_pack #(.ADDRW(ADDRW)) u_pack0 (
    .op_i   (op0_i),
    .stn_i  (stn0),
    .dst_i  (dst0_i),
    .sa_i   (src_ren[0]),
    .sb_i   (src_ren[1]),
    .addr_i (addr0_i),
    .word_o (word0_n)
  );

  dd_pack #(.ADDRW(ADDRW)) u_pack1 (
    .op_i   (op1_i),
    .stn_i  (stn1),
    .dst_i  (dst1_i),
    .sa_i   (src_ren[2]),
    .sb_i   (src_ren[3]),
    .addr_i (addr1_i),
    .word_o (word1_n)
  );

  logic [1:0] take_n;
  logic       halted_n;
  assign take_n   = {stn1 != '0, stn0 != '0};
  assign halted_n = halted_q | exc_i;

  // ---------------- registers
  logic [WW-1:0] bus0_q, bus1_q;
  logic [1:0]    take_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus0_q   <= '0;
      bus1_q   <= '0;
      take_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      bus0_q <= word0_n;
      bus1_q <= word1_n;
      take_q <= take_n;
      if (exc_i) halted_q <= halted_n;
    end
  end

  assign bus0_o = bus0_q;
  assign bus1_o = bus1_q;
  assign take_o = take_q;

  // ---------------- assertions
  tag_t rt0, rt1;
  op_t  op1_out;
  assign rt0     = bus0_q[STN_LSB +: TW];
  assign rt1     = bus1_q[STN_LSB +: TW];
  assign op1_out = bus1_q[OP_LSB +: OPW];

  AST_TWO_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rt0 != '0) && (rt1 != '0)) |-> (rt0 != rt1));                              // R2

  AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rt1 != '0) |-> (rt1[TW-1:1] == class_base(op1_out)[TW-1:1]));               // R2

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rt0 != '0) |-> ((($past(free_map) >> rt0) & 16'd1) != 16'd0));             // R3

  AST_DEP_HOLDS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dep) && $past(slot0_live) && (rt0 == '0)) |-> (rt1 == '0));           // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> ((take_q == 2'b00) && (bus0_q == '0) && (bus1_q == '0)));        // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);                                                      // R9

endmodule

// File: tb/test_dual_dispatch.sv
module test_dual_dispatch;

  localparam int ADDRW = 32;
  localparam int W     = 51;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             exc_i;
  logic [2:0]       op0_i, op1_i;
  logic [3:0]       dst0_i, srca0_i, srcb0_i, dst1_i, srca1_i, srcb1_i;
  logic [ADDRW-1:0] addr0_i, addr1_i;
  logic [7:0]       busy_i;
  logic [15:0]      rmap_i;
  logic [15:0]      ret_i;
  logic [W-1:0]     bus0_o, bus1_o;
  logic [1:0]       take_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  dual_dispatch i_dual_dispatch (
    .clk(clk), .rst_n(rst_n), .exc_i(exc_i),
    .op0_i(op0_i), .dst0_i(dst0_i), .srca0_i(srca0_i), .srcb0_i(srcb0_i), .addr0_i(addr0_i),
    .op1_i(op1_i), .dst1_i(dst1_i), .srca1_i(srca1_i), .srcb1_i(srcb1_i), .addr1_i(addr1_i),
    .busy_i(busy_i), .rmap_i(rmap_i), .ret_i(ret_i),
    .bus0_o(bus0_o), .bus1_o(bus1_o), .take_o(take_o)
  );

  function automatic logic [W-1:0] mk(logic [2:0] op, logic [3:0] st, logic [3:0] d,
                                      logic [3:0] a, logic [3:0] b, logic [31:0] ad);
    return {op, st, d, a, b, ad};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot0(logic [2:0] op, logic [3:0] d, logic [3:0] a, logic [3:0] b, logic [31:0] ad);
    op0_i = op; dst0_i = d; srca0_i = a; srcb0_i = b; addr0_i = ad;
  endtask

  task automatic slot1(logic [2:0] op, logic [3:0] d, logic [3:0] a, logic [3:0] b, logic [31:0] ad);
    op1_i = op; dst1_i = d; srca1_i = a; srcb1_i = b; addr1_i = ad;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 bus0 in reset", 64'(bus0_o), 64'd0);
    chk("R1 take in reset", 64'(take_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 bus1 after release", 64'(bus1_o), 64'd0);
    chk("R1 take after release", 64'(take_o), 64'd0);
  endtask

  task automatic t_alloc();
    @(negedge clk);
    busy_i = 8'h00; rmap_i = '0; ret_i = '0;
    slot0(3'd2, 4'd5, 4'd7, 4'd7, 32'hDEAD_BEEF);
    slot1(3'd2, 4'd6, 4'd4, 4'd4, 32'h0);
    settle();
    chk("R2 R8 slot0 lowest adder", 64'(bus0_o), 64'(mk(3'd2, 4'd8, 4'd5, 4'd7, 4'd7, 32'h0)));
    chk("R2 slot1 next adder", 64'(bus1_o), 64'(mk(3'd2, 4'd9, 4'd6, 4'd4, 4'd4, 32'h0)));
    chk("R2 take both", 64'(take_o), 64'd3);
  endtask

  task automatic t_mem();
    @(negedge clk);
    slot0(3'd6, 4'd6, 4'd5, 4'd5, 32'h1234_5678);
    slot1(3'd7, 4'd5, 4'd7, 4'd5, 32'hABCD_0000);
    settle();
    chk("R8 load word", 64'(bus0_o), 64'(mk(3'd6, 4'd12, 4'd6, 4'd0, 4'd0, 32'h1234_5678)));
    chk("R8 R2 store word", 64'(bus1_o), 64'(mk(3'd7, 4'd14, 4'd0, 4'd7, 4'd0, 32'hABCD_0000)));
  endtask

  task automatic t_full_overtake();
    @(negedge clk);
    busy_i = 8'b0000_0011;
    slot0(3'd2, 4'd5, 4'd4, 4'd4, 32'h0);
    slot1(3'd4, 4'd6, 4'd7, 4'd7, 32'h0);
    settle();
    chk("R4 slot0 stalled word", 64'(bus0_o), 64'd0);
    chk("R7 slot1 overtakes", 64'(bus1_o), 64'(mk(3'd4, 4'd10, 4'd6, 4'd7, 4'd7, 32'h0)));
    chk("R4 R7 take slot1 only", 64'(take_o), 64'd2);
  endtask

  task automatic t_dep_stall();
    @(negedge clk);
    slot1(3'd4, 4'd6, 4'd5, 4'd7, 32'h0);
    settle();
    chk("R7 raw stalls slot1", 64'(bus1_o), 64'd0);
    chk("R7 raw take none", 64'(take_o), 64'd0);
    @(negedge clk);
    slot1(3'd4, 4'd4, 4'd7, 4'd7, 32'h0);
    settle();
    chk("R7 war stalls slot1", 64'(bus1_o), 64'd0);
  endtask

  task automatic t_freed();
    @(negedge clk);
    busy_i = 8'b0000_0011;
    ret_i  = {4'd0, 4'd9, 4'd0, 4'd0};
    slot0(3'd2, 4'd5, 4'd4, 4'd4, 32'h0);
    slot1(3'd2, 4'd6, 4'd7, 4'd7, 32'h0);
    settle();
    chk("R3 returned station claimed", 64'(bus0_o), 64'(mk(3'd2, 4'd9, 4'd5, 4'd4, 4'd4, 32'h0)));
    chk("R3 R4 no second adder", 64'(bus1_o), 64'd0);
    chk("R3 take slot0", 64'(take_o), 64'd1);
  endtask

  task automatic t_rename();
    @(negedge clk);
    busy_i = 8'h00;
    rmap_i = {4'd10, 4'd0, 4'd0, 4'd12};
    ret_i  = {4'd0, 4'd0, 4'd0, 4'd12};
    slot0(3'd2, 4'd5, 4'd7, 4'd4, 32'h0);
    slot1(3'd0, 4'd0, 4'd0, 4'd0, 32'h0);
    settle();
    chk("R5 mapped and leaving owner", 64'(bus0_o), 64'(mk(3'd2, 4'd8, 4'd5, 4'd10, 4'd4, 32'h0)));
    @(negedge clk);
    ret_i = '0;
    settle();
    chk("R5 both mapped", 64'(bus0_o), 64'(mk(3'd2, 4'd8, 4'd5, 4'd10, 4'd12, 32'h0)));
  endtask

  task automatic t_forward();
    @(negedge clk);
    rmap_i = {4'd0, 4'd0, 4'd13, 4'd0};
    slot0(3'd2, 4'd5, 4'd4, 4'd4, 32'h0);
    slot1(3'd4, 4'd6, 4'd5, 4'd5, 32'h0);
    settle();
    chk("R6 pair forwarding", 64'(bus1_o), 64'(mk(3'd4, 4'd10, 4'd6, 4'd8, 4'd8, 32'h0)));
    chk("R6 take both", 64'(take_o), 64'd3);
  endtask

  task automatic t_empty_timing();
    @(negedge clk);
    rmap_i = '0;
    slot0(3'd0, 4'd5, 4'd4, 4'd4, 32'h0);
    slot1(3'd2, 4'd6, 4'd4, 4'd4, 32'h0);
    #2;
    chk("R10 held until edge", 64'(bus1_o), 64'(mk(3'd4, 4'd10, 4'd6, 4'd8, 4'd8, 32'h0)));
    settle();
    chk("R10 empty slot0 word", 64'(bus0_o), 64'd0);
    chk("R10 slot1 takes lowest adder", 64'(bus1_o), 64'(mk(3'd2, 4'd8, 4'd6, 4'd4, 4'd4, 32'h0)));
    chk("R10 take slot1", 64'(take_o), 64'd2);
  endtask

  task automatic t_exception();
    @(negedge clk);
    exc_i = 1'b1;
    slot0(3'd2, 4'd5, 4'd4, 4'd4, 32'h0);
    slot1(3'd4, 4'd6, 4'd7, 4'd7, 32'h0);
    settle();
    chk("R9 no issue with exception", 64'(take_o), 64'd0);
    @(negedge clk);
    exc_i = 1'b0;
    settle();
    chk("R9 still halted word", 64'(bus0_o), 64'd0);
    chk("R9 still halted take", 64'(take_o), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; exc_i = 1'b0;
    busy_i = '0; rmap_i = '0; ret_i = '0;
    slot0(3'd0, 4'd0, 4'd0, 4'd0, 32'h0);
    slot1(3'd0, 4'd0, 4'd0, 4'd0, 32'h0);
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_alloc();
    t_mem();
    t_full_overtake();
    t_dep_stall();
    t_freed();
    t_rename();
    t_forward();
    t_empty_timing();
    t_exception();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule